// File: doc/BRIEF.md
# Private Interrupt Best-Pending Selector

This block looks at the 32 private interrupts of one processor and picks the one that should be signalled next. It first reduces the per-interrupt state to one qualified pending bit each. That state is the latched pending flag, the trigger configuration, the input line level, enable, active, and the two group bits. Each qualified interrupt then competes on its 8-bit priority value. A lower value is more urgent, and on equal values the lower ID wins.

A scan begins with a one-cycle `start` pulse while the block is idle. It visits one interrupt per clock in ascending ID order. When the last ID has been visited, an externally supplied best locally-signalled candidate may replace the private winner. That candidate carries a 16-bit ID, its priority and its group, and it is used only when the enable conditions allow it. A one-cycle `done` pulse then marks the ID, priority and group outputs as final. A priority of 0xFF on the output means that nothing is pending.

Top module: `intr_best_pick`

## Requirements
- R1: An interrupt is pending when its latched pending bit is 1, or when its trigger bit is 0 (level-sensitive) and its line input is 1. A line that is high on an interrupt whose trigger bit is 1 (edge) does not make it pending.
- R2: A pending interrupt takes part in the selection only if its enable bit is 1 and its active bit is 0.
- R3: While `ds_i` is 1, every group-modifier bit is treated as 0.
- R4: An interrupt with group bit 1 passes only if `en_ns1_i` is 1. One with group 0 and modifier 1 passes only if `en_s1_i` is 1. One with group 0 and modifier 0 passes only if `en_g0_i` is 1.
- R5: A candidate replaces the current best when its priority value is numerically lower. On equal priority it replaces the best when its ID is less than or equal to the best ID. The search starts from priority 0xFF and ID 0, so among equal private priorities the lowest ID wins.
- R6: When no interrupt qualifies and the external candidate is not taken, the scan ends with `best_prio_o` = 0xFF and `best_id_o` = 0.
- R7: The external candidate takes part only when `lpi_cpu_en_i`, `lpi_glb_en_i` and `en_ns1_i` are all 1 and `lpi_prio_i` is not 0xFF. It then replaces the private result by the rule of R5.
- R8: The group is encoded as 0 for Group 0, 1 for secure Group 1 and 2 for non-secure Group 1. `best_grp_o` changes only at the end of a scan, and only if a winner was found during that scan. A private winner's group comes from its group bit and its effective modifier. An external winner's group comes from `lpi_grp_i`. Otherwise `best_grp_o` keeps its previous value.
- R9: `start` while idle sets `busy_o` on the next edge. `busy_o` then stays high for exactly 32 cycles, and `done_o` is high for one cycle right after it. `start` while busy has no effect. During the `done_o` cycle a new start is accepted.
- R10: After reset, `busy_o` and `done_o` are 0, `best_prio_o` is 0xFF, `best_id_o` is 0 and `best_grp_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a scan (accepted when idle) |
| pend_i | input | 32 | Latched pending bits |
| trig_edge_i | input | 32 | Trigger configuration, 1 = edge, 0 = level |
| line_i | input | 32 | Input line levels |
| enable_i | input | 32 | Enable bits |
| active_i | input | 32 | Active bits |
| group_i | input | 32 | Group bits |
| grpmod_i | input | 32 | Group-modifier bits |
| prio_i | input | 256 | Priorities, interrupt n at bits [8n+7:8n] |
| ds_i | input | 1 | Disable-security control |
| en_g0_i | input | 1 | Group 0 enable |
| en_s1_i | input | 1 | Secure Group 1 enable |
| en_ns1_i | input | 1 | Non-secure Group 1 enable |
| lpi_cpu_en_i | input | 1 | Per-processor enable for the external candidate |
| lpi_glb_en_i | input | 1 | Global enable for the external candidate |
| lpi_id_i | input | 16 | External candidate ID |
| lpi_prio_i | input | 8 | External candidate priority |
| lpi_grp_i | input | 2 | External candidate group code |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| best_id_o | output | 16 | Winning ID |
| best_prio_o | output | 8 | Winning priority (0xFF = none) |
| best_grp_o | output | 2 | Winning group code |

## Verification
The properties assume that `start_i` is a clean synchronous input and that the interrupt state vectors, priorities and control bits do not change while `busy_o` is high. The result is formed across 32 cycles from inputs that are read live. The stimulus changes any of these inputs only while the block is idle. The single exception is a deliberate `start_i` pulse in the middle of a scan, which checks that such a pulse is ignored. The external candidate's group code is always driven as 0, 1 or 2, so the property that the reported group never reads 3 rests on that input being well formed.

// File: rtl/psel_pkg.sv
package psel_pkg;

    typedef enum logic [1:0] {
        GRP_G0  = 2'd0,
        GRP_S1  = 2'd1,
        GRP_NS1 = 2'd2
    } grp_e;

endpackage

// File: rtl/psel_qualify.sv
module psel_qualify
    import psel_pkg::*;
#(
    parameter int NUM_INT = 32
) (
    input  logic [NUM_INT-1:0] pend_i,
    input  logic [NUM_INT-1:0] trig_edge_i,
    input  logic [NUM_INT-1:0] line_i,
    input  logic [NUM_INT-1:0] enable_i,
    input  logic [NUM_INT-1:0] active_i,
    input  logic [NUM_INT-1:0] group_i,
    input  logic [NUM_INT-1:0] grpmod_i,
    input  logic               ds_i,
    input  logic               en_g0_i,
    input  logic               en_s1_i,
    input  logic               en_ns1_i,
    output logic [NUM_INT-1:0] qual_o,
    output grp_e               grp_o [NUM_INT]
);

    logic [NUM_INT-1:0] raw_pend;
    logic [NUM_INT-1:0] eff_mod;
    logic [NUM_INT-1:0] grp_pass;

    always_comb begin
        raw_pend = pend_i | (~trig_edge_i & line_i);
        eff_mod  = ds_i ? '0 : grpmod_i;
        grp_pass = '0;
        if (en_ns1_i) grp_pass = grp_pass | group_i;
        if (en_s1_i)  grp_pass = grp_pass | (~group_i & eff_mod);
        if (en_g0_i)  grp_pass = grp_pass | (~group_i & ~eff_mod);
        qual_o = raw_pend & enable_i & ~active_i & grp_pass;
    end

    for (genvar g = 0; g < NUM_INT; g++) begin : g_grp
        always_comb begin
            if (group_i[g])       grp_o[g] = GRP_NS1;
            else if (eff_mod[g])  grp_o[g] = GRP_S1;
            else                  grp_o[g] = GRP_G0;
        end
    end

endmodule

// File: rtl/psel_better.sv
module psel_better #(
    parameter int PRIO_W = 8,
    parameter int ID_W   = 16
) (
    input  logic [PRIO_W-1:0] cand_prio_i,
    input  logic [ID_W-1:0]   cand_id_i,
    input  logic [PRIO_W-1:0] best_prio_i,
    input  logic [ID_W-1:0]   best_id_i,
    output logic              wins_o
);

    always_comb begin
        wins_o = (cand_prio_i < best_prio_i) ||
                 ((cand_prio_i == best_prio_i) && (cand_id_i <= best_id_i));
    end

endmodule

// File: rtl/psel_lpi_gate.sv
module psel_lpi_gate #(
    parameter int PRIO_W = 8
) (
    input  logic              cpu_en_i,
    input  logic              glb_en_i,
    input  logic              ns1_en_i,
    input  logic [PRIO_W-1:0] prio_i,
    output logic              ok_o
);

    localparam logic [PRIO_W-1:0] NONE = '1;

    always_comb begin
        ok_o = cpu_en_i && glb_en_i && ns1_en_i && (prio_i != NONE);
    end

endmodule

// File: rtl/intr_best_pick.sv
module intr_best_pick
    import psel_pkg::*;
#(
    parameter int NUM_INT = 32,
    parameter int PRIO_W  = 8,
    parameter int ID_W    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [NUM_INT-1:0]        pend_i,
    input  logic [NUM_INT-1:0]        trig_edge_i,
    input  logic [NUM_INT-1:0]        line_i,
    input  logic [NUM_INT-1:0]        enable_i,
    input  logic [NUM_INT-1:0]        active_i,
    input  logic [NUM_INT-1:0]        group_i,
    input  logic [NUM_INT-1:0]        grpmod_i,
    input  logic [NUM_INT*PRIO_W-1:0] prio_i,
    input  logic                      ds_i,
    input  logic                      en_g0_i,
    input  logic                      en_s1_i,
    input  logic                      en_ns1_i,
    input  logic                      lpi_cpu_en_i,
    input  logic                      lpi_glb_en_i,
    input  logic [ID_W-1:0]           lpi_id_i,
    input  logic [PRIO_W-1:0]         lpi_prio_i,
    input  logic [1:0]                lpi_grp_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [ID_W-1:0]           best_id_o,
    output logic [PRIO_W-1:0]         best_prio_o,
    output logic [1:0]                best_grp_o
);

    localparam int IDX_W = $clog2(NUM_INT);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_INT - 1);
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [IDX_W-1:0]  idx;
        logic [ID_W-1:0]   best_id;
        logic [PRIO_W-1:0] best_prio;
        logic [1:0]        best_grp;
        logic [1:0]        run_grp;
        logic              seen;
    } state_t;

    localparam state_t STATE_RST = '{
        busy:      1'b0,
        done:      1'b0,
        idx:       '0,
        best_id:   '0,
        best_prio: PRIO_NONE,
        best_grp:  2'd0,
        run_grp:   2'd0,
        seen:      1'b0
    };

    state_t st_d, st_q;

    logic [NUM_INT-1:0] qual;
    grp_e               grp_vec [NUM_INT];
    logic [PRIO_W-1:0]  cur_prio;
    logic [ID_W-1:0]    cur_id;
    logic               priv_win;
    logic               lpi_ok;
    logic               lpi_win;
    logic [ID_W-1:0]    mid_id;
    logic [PRIO_W-1:0]  mid_prio;
    logic [1:0]         mid_grp;
    logic               mid_seen;

    psel_qualify #(.NUM_INT(NUM_INT)) u_qual (
        .pend_i      (pend_i),
        .trig_edge_i (trig_edge_i),
        .line_i      (line_i),
        .enable_i    (enable_i),
        .active_i    (active_i),
        .group_i     (group_i),
        .grpmod_i    (grpmod_i),
        .ds_i        (ds_i),
        .en_g0_i     (en_g0_i),
        .en_s1_i     (en_s1_i),
        .en_ns1_i    (en_ns1_i),
        .qual_o      (qual),
        .grp_o       (grp_vec)
    );

    always_comb begin
        cur_prio = prio_i[int'(st_q.idx)*PRIO_W +: PRIO_W];
        cur_id   = {{(ID_W-IDX_W){1'b0}}, st_q.idx};
    end

    psel_better #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_priv_cmp (
        .cand_prio_i (cur_prio),
        .cand_id_i   (cur_id),
        .best_prio_i (st_q.best_prio),
        .best_id_i   (st_q.best_id),
        .wins_o      (priv_win)
    );

    // Best after this cycle's private candidate, before the external merge.
    always_comb begin
        mid_id   = st_q.best_id;
        mid_prio = st_q.best_prio;
        mid_grp  = st_q.run_grp;
        mid_seen = st_q.seen;
        if (qual[st_q.idx] && priv_win) begin
            mid_id   = cur_id;
            mid_prio = cur_prio;
            mid_grp  = grp_vec[st_q.idx];
            mid_seen = 1'b1;
        end
    end

    psel_lpi_gate #(.PRIO_W(PRIO_W)) u_lpi_gate (
        .cpu_en_i (lpi_cpu_en_i),
        .glb_en_i (lpi_glb_en_i),
        .ns1_en_i (en_ns1_i),
        .prio_i   (lpi_prio_i),
        .ok_o     (lpi_ok)
    );

    psel_better #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_lpi_cmp (
        .cand_prio_i (lpi_prio_i),
        .cand_id_i   (lpi_id_i),
        .best_prio_i (mid_prio),
        .best_id_i   (mid_id),
        .wins_o      (lpi_win)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy      = 1'b1;
                st_d.idx       = '0;
                st_d.best_id   = '0;
                st_d.best_prio = PRIO_NONE;
                st_d.seen      = 1'b0;
            end
        end else begin
            st_d.best_id   = mid_id;
            st_d.best_prio = mid_prio;
            st_d.run_grp   = mid_grp;
            st_d.seen      = mid_seen;
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                if (lpi_ok && lpi_win) begin
                    st_d.best_id   = lpi_id_i;
                    st_d.best_prio = lpi_prio_i;
                    st_d.best_grp  = lpi_grp_i;
                end else if (mid_seen) begin
                    st_d.best_grp  = mid_grp;
                end
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= STATE_RST;
        else        st_q <= st_d;
    end

    assign busy_o      = st_q.busy;
    assign done_o      = st_q.done;
    assign best_id_o   = st_q.best_id;
    assign best_prio_o = st_q.best_prio;
    assign best_grp_o  = st_q.best_grp;

endmodule

// File: rtl/intr_best_pick_chk.sv
module intr_best_pick_chk #(
    parameter int NUM_INT = 32,
    parameter int PRIO_W  = 8,
    parameter int ID_W    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [ID_W-1:0]   best_id_o,
    input logic [PRIO_W-1:0] best_prio_o,
    input logic [1:0]        best_grp_o
);

    localparam int CW = $clog2(NUM_INT + 2);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)      busy_cnt <= '0;
        else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
        else             busy_cnt <= '0;
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_full_scan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt == CW'(NUM_INT)) && !busy_o);

    assert_scan_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_cnt < CW'(NUM_INT)));

    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(best_prio_o) && $stable(best_id_o)));

    assert_grp_only_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(best_grp_o));

    assert_grp_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        best_grp_o != 2'd3);

endmodule

bind intr_best_pick intr_best_pick_chk #(
    .NUM_INT (NUM_INT),
    .PRIO_W  (PRIO_W),
    .ID_W    (ID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .best_id_o   (best_id_o),
    .best_prio_o (best_prio_o),
    .best_grp_o  (best_grp_o)
);

// File: tb/sim_intr_best_pick.sv
`timescale 1ns/1ps
module sim_intr_best_pick;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [31:0] pend_i, trig_edge_i, line_i, enable_i, active_i, group_i, grpmod_i;
    logic [255:0] prio_i;
    logic ds_i, en_g0_i, en_s1_i, en_ns1_i, lpi_cpu_en_i, lpi_glb_en_i;
    logic [15:0] lpi_id_i;
    logic [7:0]  lpi_prio_i;
    logic [1:0]  lpi_grp_i;
    logic busy_o, done_o;
    logic [15:0] best_id_o;
    logic [7:0]  best_prio_o;
    logic [1:0]  best_grp_o;

    always #4 clk = ~clk;

    intr_best_pick u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .pend_i(pend_i), .trig_edge_i(trig_edge_i), .line_i(line_i),
        .enable_i(enable_i), .active_i(active_i), .group_i(group_i),
        .grpmod_i(grpmod_i), .prio_i(prio_i), .ds_i(ds_i),
        .en_g0_i(en_g0_i), .en_s1_i(en_s1_i), .en_ns1_i(en_ns1_i),
        .lpi_cpu_en_i(lpi_cpu_en_i), .lpi_glb_en_i(lpi_glb_en_i),
        .lpi_id_i(lpi_id_i), .lpi_prio_i(lpi_prio_i), .lpi_grp_i(lpi_grp_i),
        .busy_o(busy_o), .done_o(done_o), .best_id_o(best_id_o),
        .best_prio_o(best_prio_o), .best_grp_o(best_grp_o)
    );

    int vectors = 0;
    int errors = 0;
    string cur_req = "R10";

    // Reference model state
    bit m_busy = 0, m_done = 0;
    int m_cnt = 0;
    int e_id = 0, e_prio = 255, e_grp = 0;

    task automatic compute_result();
        int bp, bid, bg, pr, gc, md;
        bit seen, p, g;
        bp = 255; bid = 0; bg = 0; seen = 0;
        for (int i = 0; i < 32; i++) begin
            p = pend_i[i] | (!trig_edge_i[i] & line_i[i]);
            p = p & enable_i[i] & !active_i[i];
            md = ds_i ? 0 : int'(grpmod_i[i]);
            if (group_i[i]) begin g = en_ns1_i; gc = 2; end
            else if (md != 0) begin g = en_s1_i; gc = 1; end
            else begin g = en_g0_i; gc = 0; end
            pr = int'(prio_i[i*8 +: 8]);
            if (p && g && (pr < bp || (pr == bp && i <= bid))) begin
                bp = pr; bid = i; bg = gc; seen = 1;
            end
        end
        e_id = bid; e_prio = bp;
        if (lpi_cpu_en_i && lpi_glb_en_i && en_ns1_i && lpi_prio_i != 8'hFF &&
            (int'(lpi_prio_i) < bp || (int'(lpi_prio_i) == bp && int'(lpi_id_i) <= bid))) begin
            e_id = int'(lpi_id_i); e_prio = int'(lpi_prio_i); e_grp = int'(lpi_grp_i);
        end else if (seen) begin
            e_grp = bg;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
            e_id = 0; e_prio = 255; e_grp = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 32) begin
                    m_busy = 0; m_done = 1;
                    compute_result();
                end
            end else if (start_i) begin
                m_busy = 1; m_cnt = 0;
            end
        end
    end

    always @(negedge clk) begin
        vectors++;
        if (busy_o !== m_busy) begin
            errors++;
            $display("FAIL R9 busy_o actual %0b expected %0b", busy_o, m_busy);
        end
        if (done_o !== m_done) begin
            errors++;
            $display("FAIL R9 done_o actual %0b expected %0b", done_o, m_done);
        end
        if (!m_busy) begin
            if (best_prio_o !== 8'(e_prio) || best_id_o !== 16'(e_id)) begin
                errors++;
                $display("FAIL %s id/prio actual %0d/%0h expected %0d/%0h",
                         cur_req, best_id_o, best_prio_o, e_id, e_prio);
            end
            if (best_grp_o !== 2'(e_grp)) begin
                errors++;
                $display("FAIL %s grp actual %0d expected %0d", cur_req, best_grp_o, e_grp);
            end
        end
    end

    task automatic clear_all();
        pend_i = '0; trig_edge_i = '1; line_i = '0; enable_i = '1; active_i = '0;
        group_i = '1; grpmod_i = '0;
        for (int i = 0; i < 32; i++) prio_i[i*8 +: 8] = 8'h80;
        ds_i = 0; en_g0_i = 1; en_s1_i = 1; en_ns1_i = 1;
        lpi_cpu_en_i = 0; lpi_glb_en_i = 0; lpi_id_i = 16'd0; lpi_prio_i = 8'hFF; lpi_grp_i = 2'd2;
    endtask

    task automatic set_prio(input int id, input logic [7:0] v);
        prio_i[id*8 +: 8] = v;
    endtask

    task automatic run_scan(input bit poke_mid);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (poke_mid) begin
            repeat (10) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            repeat (22) @(negedge clk);
        end else begin
            repeat (33) @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL R9 watchdog expired actual running expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        clear_all();
        cur_req = "R10";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: latched, level-sensitive line, and edge line ignored
        cur_req = "R1";
        pend_i[7] = 1; set_prio(7, 8'h40);
        line_i[3] = 1; set_prio(3, 8'h10);
        trig_edge_i[9] = 0; line_i[9] = 1; set_prio(9, 8'h30);
        run_scan(0);
        line_i[9] = 0;
        run_scan(0);

        // R2: disabled and active interrupts skipped
        cur_req = "R2"; clear_all();
        pend_i[2] = 1; set_prio(2, 8'h10); enable_i[2] = 0;
        pend_i[4] = 1; set_prio(4, 8'h20); active_i[4] = 1;
        pend_i[6] = 1; set_prio(6, 8'h50);
        run_scan(0);

        // R3: disable-security forces modifier to zero
        cur_req = "R3"; clear_all();
        pend_i[5] = 1; group_i[5] = 0; grpmod_i[5] = 1; set_prio(5, 8'h20);
        pend_i[8] = 1; set_prio(8, 8'h60);
        en_s1_i = 0; ds_i = 1;
        run_scan(0);
        ds_i = 0;
        run_scan(0);

        // R4: three-way group enables
        cur_req = "R4"; clear_all();
        pend_i[10] = 1; set_prio(10, 8'h30);
        pend_i[11] = 1; group_i[11] = 0; grpmod_i[11] = 1; set_prio(11, 8'h20);
        pend_i[12] = 1; group_i[12] = 0; set_prio(12, 8'h10);
        run_scan(0);
        en_g0_i = 0;
        run_scan(0);
        en_s1_i = 0;
        run_scan(0);
        en_ns1_i = 0;
        run_scan(0);

        // R5: ties resolved towards lower ID
        cur_req = "R5"; clear_all();
        pend_i[20] = 1; pend_i[21] = 1; pend_i[5] = 1;
        run_scan(0);
        set_prio(21, 8'h7F);
        run_scan(0);

        // R6 and R8: nothing pending, group retained
        cur_req = "R6"; clear_all();
        pend_i[0] = 1; group_i[0] = 0; set_prio(0, 8'h05);
        run_scan(0);
        pend_i = '0;
        run_scan(0);
        cur_req = "R8";
        lpi_cpu_en_i = 1; lpi_glb_en_i = 1; lpi_prio_i = 8'h30; lpi_id_i = 16'd200; lpi_grp_i = 2'd1;
        run_scan(0);
        lpi_glb_en_i = 0;
        run_scan(0);

        // R7: external candidate conditions and tie rule
        cur_req = "R7"; clear_all();
        pend_i[3] = 1; set_prio(3, 8'h40);
        lpi_cpu_en_i = 1; lpi_glb_en_i = 1; lpi_id_i = 16'd100; lpi_prio_i = 8'h20; lpi_grp_i = 2'd2;
        run_scan(0);
        lpi_cpu_en_i = 0; run_scan(0);
        lpi_cpu_en_i = 1; en_ns1_i = 0; group_i[3] = 0; run_scan(0);
        en_ns1_i = 1; group_i[3] = 1; lpi_prio_i = 8'hFF; run_scan(0);
        lpi_prio_i = 8'h40; run_scan(0);
        lpi_id_i = 16'd2; lpi_grp_i = 2'd1; run_scan(0);
        lpi_id_i = 16'd3; lpi_grp_i = 2'd0; run_scan(0);

        // R9: start during a scan ignored; start in done cycle accepted
        cur_req = "R9"; clear_all();
        pend_i[15] = 1; set_prio(15, 8'h11);
        run_scan(1);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (32) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (34) @(negedge clk);

        // R5: random patterns
        cur_req = "R5";
        for (int r = 0; r < 40; r++) begin
            pend_i = $urandom; trig_edge_i = $urandom; line_i = $urandom;
            enable_i = $urandom | $urandom; active_i = $urandom & $urandom;
            group_i = $urandom; grpmod_i = $urandom;
            for (int i = 0; i < 32; i++) prio_i[i*8 +: 8] = 8'($urandom_range(0, 15) * 16);
            ds_i = 1'($urandom); en_g0_i = 1'($urandom); en_s1_i = 1'($urandom);
            en_ns1_i = 1'($urandom); lpi_cpu_en_i = 1'($urandom); lpi_glb_en_i = 1'($urandom);
            lpi_id_i = 16'($urandom_range(0, 40)); lpi_prio_i = 8'($urandom_range(0, 15) * 16 + 15);
            lpi_grp_i = 2'($urandom_range(0, 2));
            run_scan(0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule